// File: doc/BRIEF.md
# Ring Privilege and I/O Permission Guard

This block holds the current privilege level of a simple core and judges every request the core issues against that level. Four levels exist, numbered 0 (most trusted) to 3 (least trusted). Anything open to level n is also open to every level below n. The block also owns a flags register that carries a 2-bit I/O privilege field. Port accesses are compared against that field instead of a fixed level.

The core presents one request per cycle with an operation code, a target level and a flags write value. One cycle later the block answers with a registered grant or a protection fault. On the same edge it applies any change to the current level or to the flags. A core can always drop to an outer ring. It can only move inward through a gate call whose target is no less trusted than its present level, or through interrupt entry. Only ring 0 may rewrite the I/O privilege field.

Top module: `ring_guard`

## Requirements
- R1: While reset is asserted and after it is released, the current level reads 0, the flags read all zero and neither grant nor fault is raised.
- R2: Operation codes are: 0 port access, 1 flags pop, 2 interrupt return, 3 privileged instruction, 4 gate call, 5 interrupt entry, 6 return to outer ring, 7 reserved. Each valid request gets exactly one of grant or fault in the next cycle, and code 7 always faults. A cycle with no request gives neither.
- R3: A port access is granted when the current level is numerically less than or equal to the I/O privilege field, which is flags bits 13:12. Otherwise it faults.
- R4: A flags pop issued at level 0 is granted and loads every flag bit, bits 13:12 included.
- R5: A flags pop issued at levels 1 to 3 is granted and loads every flag bit except 13:12, which keep their old value.
- R6: A privileged instruction is granted only at level 0 and faults at any other level.
- R7: A gate call is granted when its target level is numerically less than or equal to the current level, and the current level becomes the target. A gate call to a less trusted level faults.
- R8: Interrupt entry is always granted. It sets the current level to 0 and leaves the flags unchanged.
- R9: A return is granted when its target level is numerically greater than or equal to the current level, and the current level becomes the target. A return to a more trusted level faults.
- R10: An interrupt return follows the level rule of R9. When granted, it also writes the flags under the R4/R5 rule, judged at the level in force before the return.
- R11: A faulted request changes neither the current level nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_op_i | input | 3 | Operation code (see R2) |
| req_lvl_i | input | 2 | Target level for gate call, return and interrupt return |
| req_flags_i | input | FLAG_W | Flags write value for flags pop and interrupt return |
| grant_o | output | 1 | Previous-cycle request granted |
| fault_o | output | 1 | Previous-cycle request refused (protection fault) |
| cpl_o | output | 2 | Current privilege level |
| flags_o | output | FLAG_W | Flags register, I/O privilege field in bits 13:12 |

## Verification
Directed sequences walk the level through 0, 3, 2, 0, 1 and 3. At each level they try port access, so that level equal to the field, below it and above it give different answers. They also try flags writes with all-ones data, which shows whether the I/O field is locked or loaded. Gate calls and returns are tried with targets on both sides of the current level and equal to it, which separates permitted moves from refused ones. A long random run then mixes every operation code, target level, write value and idle cycle. A bench model predicts the response, the level and the flags after each request, which exposes wrong comparisons, missed field locks and state changes on faults.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_TOP = '0;

  typedef enum logic [2:0] {
    OP_IO   = 3'd0,
    OP_POPF = 3'd1,
    OP_IRET = 3'd2,
    OP_PRIV = 3'd3,
    OP_GATE = 3'd4,
    OP_INTR = 3'd5,
    OP_RET  = 3'd6,
    OP_RSVD = 3'd7
  } ring_op_e;

  typedef struct packed {
    logic             grant;
    logic             load_lvl;
    logic [LVL_W-1:0] new_lvl;
    logic             load_flags;
    logic             keep_iopl;
  } ring_dec_t;
endpackage

// File: rtl/ring_policy.sv
module ring_policy
  import ring_pkg::*;
(
  input  logic             valid_i,
  input  ring_op_e         op_i,
  input  logic [LVL_W-1:0] tgt_i,
  input  logic [LVL_W-1:0] cpl_i,
  input  logic [LVL_W-1:0] iopl_i,
  output ring_dec_t        dec_o
);
  ring_dec_t raw;
  logic      at_top;
  logic      inward_ok;
  logic      outward_ok;

  assign at_top     = (cpl_i == LVL_TOP);
  assign inward_ok  = (tgt_i <= cpl_i);
  assign outward_ok = (tgt_i >= cpl_i);

  always_comb begin
    raw = '0;
    case (op_i)
      OP_IO:   raw.grant = (cpl_i <= iopl_i);
      OP_POPF: begin
        raw.grant      = 1'b1;
        raw.load_flags = 1'b1;
        raw.keep_iopl  = !at_top;
      end
      OP_IRET: begin
        raw.grant      = outward_ok;
        raw.load_flags = outward_ok;
        raw.keep_iopl  = !at_top;
        raw.load_lvl   = outward_ok;
        raw.new_lvl    = tgt_i;
      end
      OP_PRIV: raw.grant = at_top;
      OP_GATE: begin
        raw.grant    = inward_ok;
        raw.load_lvl = inward_ok;
        raw.new_lvl  = tgt_i;
      end
      OP_INTR: begin
        raw.grant    = 1'b1;
        raw.load_lvl = 1'b1;
        raw.new_lvl  = LVL_TOP;
      end
      OP_RET: begin
        raw.grant    = outward_ok;
        raw.load_lvl = outward_ok;
        raw.new_lvl  = tgt_i;
      end
      default: raw = '0;
    endcase
  end

  always_comb begin
    dec_o = raw;
    if (!valid_i) begin
      dec_o.grant      = 1'b0;
      dec_o.load_lvl   = 1'b0;
      dec_o.load_flags = 1'b0;
    end
  end
endmodule

// File: rtl/ring_flags.sv
module ring_flags
  import ring_pkg::*;
#(
  parameter int FLAG_W   = 16,
  parameter int IOPL_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              keep_iopl_i,
  input  logic [FLAG_W-1:0] wdata_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [LVL_W-1:0]  iopl_o
);
  localparam logic [FLAG_W-1:0] IOPL_MASK = {{(FLAG_W-LVL_W){1'b0}}, {LVL_W{1'b1}}} << IOPL_LSB;

  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    flags_d = wdata_i;
    if (keep_iopl_i) flags_d = (wdata_i & ~IOPL_MASK) | (flags_q & IOPL_MASK);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (we_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign iopl_o  = flags_q[IOPL_LSB +: LVL_W];
endmodule

// File: rtl/ring_level.sv
module ring_level
  import ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  ring_dec_t        dec_i,
  output logic [LVL_W-1:0] cpl_o,
  output logic             grant_o,
  output logic             fault_o
);
  logic [LVL_W-1:0] cpl_q;
  logic             grant_q;
  logic             fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpl_q   <= LVL_TOP;
      grant_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (dec_i.load_lvl) cpl_q <= dec_i.new_lvl;
      grant_q <= valid_i & dec_i.grant;
      fault_q <= valid_i & ~dec_i.grant;
    end
  end

  assign cpl_o   = cpl_q;
  assign grant_o = grant_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/ring_guard.sv
module ring_guard
  import ring_pkg::*;
#(
  parameter int FLAG_W   = 16,
  parameter int IOPL_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [1:0]        req_lvl_i,
  input  logic [FLAG_W-1:0] req_flags_i,
  output logic              grant_o,
  output logic              fault_o,
  output logic [1:0]        cpl_o,
  output logic [FLAG_W-1:0] flags_o
);
  ring_dec_t        dec;
  logic [LVL_W-1:0] cpl;
  logic [LVL_W-1:0] iopl;

  ring_policy u_policy (
    .valid_i (req_valid_i),
    .op_i    (ring_op_e'(req_op_i)),
    .tgt_i   (req_lvl_i),
    .cpl_i   (cpl),
    .iopl_i  (iopl),
    .dec_o   (dec)
  );

  ring_flags #(
    .FLAG_W   (FLAG_W),
    .IOPL_LSB (IOPL_LSB)
  ) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (dec.load_flags),
    .keep_iopl_i (dec.keep_iopl),
    .wdata_i     (req_flags_i),
    .flags_o     (flags_o),
    .iopl_o      (iopl)
  );

  ring_level u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .dec_i   (dec),
    .cpl_o   (cpl),
    .grant_o (grant_o),
    .fault_o (fault_o)
  );

  assign cpl_o = cpl;
endmodule

// File: rtl/ring_guard_chk.sv
module ring_guard_chk
  import ring_pkg::*;
#(
  parameter int FLAG_W   = 16,
  parameter int IOPL_LSB = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        req_op_i,
  input logic [1:0]        req_lvl_i,
  input logic [FLAG_W-1:0] req_flags_i,
  input logic              grant_o,
  input logic              fault_o,
  input logic [1:0]        cpl_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic [1:0] iopl;
  assign iopl = flags_o[IOPL_LSB +: 2];

  assert_one_resp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (grant_o ^ fault_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!grant_o && !fault_o && $stable(cpl_o) && $stable(flags_o)));

  assert_io_refuse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_IO && cpl_o > iopl) |=> fault_o);

  assert_io_allow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_IO && cpl_o <= iopl) |=> grant_o);

  assert_iopl_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cpl_o != 2'd0) |=> $stable(flags_o[IOPL_LSB +: 2]));

  assert_priv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_PRIV && cpl_o != 2'd0) |=> fault_o);

  assert_no_inward_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i != OP_GATE && req_op_i != OP_INTR) |=> (cpl_o >= $past(cpl_o)));

  assert_intr_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_INTR) |=> (grant_o && cpl_o == 2'd0 && $stable(flags_o)));

  assert_fault_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ($stable(cpl_o) && $stable(flags_o)));
endmodule

bind ring_guard ring_guard_chk #(
  .FLAG_W   (FLAG_W),
  .IOPL_LSB (IOPL_LSB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_lvl_i   (req_lvl_i),
  .req_flags_i (req_flags_i),
  .grant_o     (grant_o),
  .fault_o     (fault_o),
  .cpl_o       (cpl_o),
  .flags_o     (flags_o)
);

// File: tb/ring_guard_tb.sv
module ring_guard_tb;
  localparam int FW = 16;
  localparam int IL = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [2:0]    op = '0;
  logic [1:0]    lvl = '0;
  logic [FW-1:0] wflags = '0;
  logic          grant, fault;
  logic [1:0]    cpl;
  logic [FW-1:0] flags;

  int n_vec = 0;
  int n_bad = 0;
  logic [1:0]    m_cpl = '0;
  logic [FW-1:0] m_flags = '0;

  always #4 clk = ~clk;

  ring_guard #(.FLAG_W(FW), .IOPL_LSB(IL)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_op_i(op),
    .req_lvl_i(lvl), .req_flags_i(wflags), .grant_o(grant), .fault_o(fault),
    .cpl_o(cpl), .flags_o(flags)
  );

  function automatic logic [FW-1:0] merge(input logic [1:0] at, input logic [FW-1:0] old, input logic [FW-1:0] w);
    logic [FW-1:0] r;
    r = w;
    if (at != 2'd0) r[IL +: 2] = old[IL +: 2];
    return r;
  endfunction

  function automatic logic judge(input logic [2:0] o, input logic [1:0] t, input logic [1:0] c, input logic [FW-1:0] f);
    case (o)
      3'd0: return c <= f[IL +: 2];
      3'd1: return 1'b1;
      3'd2: return t >= c;
      3'd3: return c == 2'd0;
      3'd4: return t <= c;
      3'd5: return 1'b1;
      3'd6: return t >= c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare(input string tag, input logic eg, input logic ef);
    logic [FW+3:0] act, exp;
    act = {grant, fault, cpl, flags};
    exp = {eg, ef, m_cpl, m_flags};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got g=%0b f=%0b cpl=%0d flags=%h, want g=%0b f=%0b cpl=%0d flags=%h",
               tag, grant, fault, cpl, flags, eg, ef, m_cpl, m_flags);
    end
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic req(input string tag, input logic [2:0] o, input logic [1:0] t, input logic [FW-1:0] w);
    logic g;
    g = judge(o, t, m_cpl, m_flags);
    valid = 1'b1; op = o; lvl = t; wflags = w;
    @(negedge clk);
    valid = 1'b0;
    if (g) begin
      if (o == 3'd1 || o == 3'd2) m_flags = merge(m_cpl, m_flags, w);
      if (o == 3'd2 || o == 3'd4 || o == 3'd6) m_cpl = t;
      if (o == 3'd5) m_cpl = 2'd0;
    end
    compare(tag, g, !g);
  endtask

  task automatic idle(input string tag);
    valid = 1'b0;
    @(negedge clk);
    compare(tag, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset", 1'b0, 1'b0);

    req("R3 io at 0 iopl 0", 3'd0, 2'd0, '0);
    req("R6 priv at 0", 3'd3, 2'd0, '0);
    req("R4 pop at 0", 3'd1, 2'd0, 16'h2ABC);
    req("R9 ret to 3", 3'd6, 2'd3, '0);
    req("R3 R11 io 3 over iopl 2", 3'd0, 2'd0, '0);
    req("R6 priv at 3", 3'd3, 2'd0, '0);
    req("R5 pop at 3 locks iopl", 3'd1, 2'd0, 16'hFFFF);
    req("R7 gate 3 to 2", 3'd4, 2'd2, '0);
    req("R3 io equal iopl", 3'd0, 2'd0, '0);
    req("R7 gate outward refused", 3'd4, 2'd3, '0);
    req("R9 ret inward refused", 3'd6, 2'd1, '0);
    req("R7 gate same level", 3'd4, 2'd2, '0);
    req("R8 intr entry", 3'd5, 2'd3, 16'h1234);
    req("R10 iret to 1 from 0", 3'd2, 2'd1, 16'h0000);
    req("R10 iret inward refused", 3'd2, 2'd0, 16'h3FFF);
    req("R10 iret to 3 keeps iopl", 3'd2, 2'd3, 16'h3000);
    req("R2 reserved op", 3'd7, 2'd0, '0);
    idle("R2 idle");
    req("R11 io refused keeps state", 3'd0, 2'd0, '0);

    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) idle("R2 random idle");
      else req("R2 R11 random", 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), FW'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule